// File: doc/BRIEF.md
# Saturating Fixed-Point Reciprocal Divider

This block divides one signed fixed-point sample by another. Every operand, the intermediate reciprocal and the result use a 28-bit signed word with 5 integer bits and 23 fraction bits. The largest magnitude is therefore just under 16.

The quotient takes two steps. The block first finds the reciprocal of the divisor's magnitude and then multiplies it by the dividend's magnitude. The sign is the XOR of the two operand signs and is applied at the end.

- **Normalisation.** A leading-one search scales the divisor into [0.5, 1).
- **Seed.** A linear seed gives the first estimate of the reciprocal.
- **Refinement.** A fixed number of Newton-Raphson steps refine the estimate, each computing x·(2 − d·x).
- **Undoing the scale.** The normalising shift is then reversed on the reciprocal.

Every product is rounded to nearest and saturated back to the 5.23 range. The reciprocal lives in that same narrow word, so a divisor of magnitude 1/16 or less clamps it at 16 − 2⁻²³. The result then comes out as roughly 15.99999988 times the dividend (for example 0.1 / 0.01 gives about 1.6).

A caller pulses `start` with the operands present and gets `done` for one cycle a fixed number of cycles later.

Top module: `recip_divider`

## Requirements
- R1: After reset `done` is 0 and `quotient` is 0.
- R2: A `start` seen while idle is followed by `done` high for exactly one cycle, on the (2·ITERS+5)-th rising edge counting the edge that samples `start` (13 with ITERS = 4). The iteration count never changes with the data.
- R3: For divisors of magnitude above 1/16 whose true quotient fits the format, `quotient` matches the ideal quotient of the two 5.23 codes to within 8 LSB plus 5 ppm (for example 1/0.7 ≈ 1.4286 and 1/0.07 ≈ 14.286).
- R4: When the divisor magnitude is 1/16 (code 0x0080000) or smaller but nonzero, the reciprocal clamps at 16 − 2⁻²³ and the result is about 15.99999988 × |dividend| with the sign of R6 (0.1 / 0.01 ≈ 1.6).
- R5: A quotient whose magnitude would reach 16 saturates to code +0x7FFFFFF or −0x7FFFFFF. The code −0x8000000 is never produced.
- R6: The result's sign is the XOR of the operand sign bits (bit 27). Its magnitude does not depend on the operand signs.
- R7: A zero divisor takes the full-scale reciprocal 16 − 2⁻²³. With |dividend| ≥ 1 the output is ±0x7FFFFFF, and a zero dividend gives 0.
- R8: A `start` pulse while a division is in flight is ignored. Exactly one `done` follows, at the R2 latency of the first `start`, carrying the first operands' quotient.
- R9: Operands are captured at the accepted `start`. Changing `dividend` or `divisor` afterwards does not alter the result.
- R10: The most negative divisor code 0x8000000 (−16) is handled as magnitude 16, so 1 / −16 gives −0.0625 (code −0x0080000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division; operands captured on this edge when idle |
| dividend | input | 28 | Numerator, signed 5.23 |
| divisor | input | 28 | Denominator, signed 5.23 |
| quotient | output | 28 | Result, signed 5.23, held until the next result |
| done | output | 1 | One-cycle pulse when `quotient` is updated |

## Verification
The assertions watch several properties on every cycle:
- `done` is always a single-cycle pulse, at the fixed distance from its load strobe.
- The sequencer enters normalisation only from idle and keeps its iteration count in range.
- The minimum code never appears at the output.
- The output sign agrees with the captured operand signs.
- A zero divisor with a dividend of at least one drives full scale.

The numeric behaviour can only be shown by the bench's scenarios, each checked against a reference model computed in real arithmetic: in-range accuracy, the clamp near 1/16, and the 1.6 result for 0.1 / 0.01. The same holds for the behaviours that need a particular input sequence: ignoring a second start, capturing operands at start, and the −16 divisor.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;

  localparam int WordW = 28;
  localparam int FracW = 23;
  localparam int ExtW  = WordW + 2;
  localparam int ProdW = 2 * ExtW;
  localparam int LeadW = $clog2(WordW);
  localparam int ExpW  = 8;

  typedef logic signed [WordW-1:0] word_t;
  typedef logic signed [ProdW-1:0] wide_t;

  localparam word_t WordMax = word_t'((64'd1 << (WordW - 1)) - 64'd1);
  localparam word_t WordMin = word_t'(64'd1 << (WordW - 1));
  localparam word_t WordTwo = word_t'(64'd2 << FracW);
  // Linear seed 48/17 - 32/17*d for d in [0.5, 1)
  localparam word_t SeedA = word_t'((64'd48 << FracW) / 64'd17);
  localparam word_t SeedB = word_t'((64'd32 << FracW) / 64'd17);

  typedef struct packed {
    logic load;
    logic norm;
    logic seed;
    logic mulA;
    logic mulB;
    logic denorm;
    logic finish;
  } strobe_t;

  function automatic wide_t widen(input word_t w);
    return wide_t'(w);
  endfunction

  function automatic word_t satWide(input wide_t v);
    if (v > widen(WordMax)) return WordMax;
    if (v < widen(WordMin)) return WordMin;
    return word_t'(v[WordW-1:0]);
  endfunction

  // Product of two 5.23 values, rounded to nearest and clamped
  function automatic word_t mulRound(input wide_t a, input wide_t b);
    wide_t p;
    p = a * b;
    p = p + (wide_t'(1) <<< (FracW - 1));
    return satWide(p >>> FracW);
  endfunction

  function automatic logic [LeadW-1:0] leadPos(input logic [WordW-1:0] v);
    logic [LeadW-1:0] pos;
    pos = '0;
    for (int i = 0; i < WordW; i++) begin
      if (v[i]) pos = LeadW'(i);
    end
    return pos;
  endfunction

  // Multiply by 2**e with saturation (e >= 0) or rounding (e < 0)
  function automatic word_t scalePow2(input word_t x, input logic signed [ExpW-1:0] e);
    wide_t v;
    int sh;
    v = widen(x);
    if (e >= 0) begin
      sh = int'(e);
      v  = v <<< sh;
    end else begin
      sh = -int'(e);
      v  = (v + (wide_t'(1) <<< (sh - 1))) >>> sh;
    end
    return satWide(v);
  endfunction

endpackage

// File: rtl/recip_div_ctrl.sv
module recip_div_ctrl
  import recip_div_pkg::*;
#(
  parameter int ITERS = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t strobe
);

  localparam int CntW = $clog2(ITERS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_NORM, S_SEED, S_MULA, S_MULB, S_DENORM, S_FINAL
  } state_e;

  state_e state, stateNext;
  logic [CntW-1:0] iterCnt;
  logic lastIter;

  assign lastIter = (iterCnt == CntW'(ITERS - 1));

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      S_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = S_NORM;
        end
      end
      S_NORM: begin
        strobe.norm = 1'b1;
        stateNext   = S_SEED;
      end
      S_SEED: begin
        strobe.seed = 1'b1;
        stateNext   = S_MULA;
      end
      S_MULA: begin
        strobe.mulA = 1'b1;
        stateNext   = S_MULB;
      end
      S_MULB: begin
        strobe.mulB = 1'b1;
        stateNext   = lastIter ? S_DENORM : S_MULA;
      end
      S_DENORM: begin
        strobe.denorm = 1'b1;
        stateNext     = S_FINAL;
      end
      S_FINAL: begin
        strobe.finish = 1'b1;
        stateNext     = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      iterCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == S_MULB) begin
        iterCnt <= lastIter ? '0 : iterCnt + 1'b1;
      end
    end
  end

  // R8: a run can only begin from idle, so a mid-run start never restarts it
  p_enter_from_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_NORM) |-> ($past(state) == S_IDLE));

  // R2: the refinement loop count stays within its fixed bound
  p_iter_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    iterCnt < CntW'(ITERS));

endmodule

// File: rtl/recip_div_path.sv
module recip_div_path
  import recip_div_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  word_t   dividend,
  input  word_t   divisor,
  output word_t   quotient,
  output logic    done
);

  logic [WordW-1:0] aMag, bMag;
  logic negRes, bZero;
  word_t dn, x, t, recip, qMag;
  logic signed [ExpW-1:0] expo;
  logic [LeadW-1:0] lead;
  logic [WordW-1:0] dnFull;

  // Magnitudes as unsigned words so that -16 becomes 2**27 exactly
  function automatic logic [WordW-1:0] magOf(input word_t v);
    return v[WordW-1] ? (~v + 1'b1) : v;
  endfunction

  assign lead   = leadPos(bMag);
  assign dnFull = bMag << (LeadW'(WordW - 1) - lead);
  assign qMag   = mulRound(wide_t'(aMag), widen(recip));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aMag     <= '0;
      bMag     <= '0;
      negRes   <= 1'b0;
      bZero    <= 1'b0;
      dn       <= '0;
      expo     <= '0;
      x        <= '0;
      t        <= '0;
      recip    <= '0;
      quotient <= '0;
      done     <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.load) begin
        aMag   <= magOf(dividend);
        bMag   <= magOf(divisor);
        negRes <= dividend[WordW-1] ^ divisor[WordW-1];
      end
      if (strobe.norm) begin
        dn    <= word_t'({{(WordW - FracW){1'b0}}, dnFull[WordW-1 -: FracW]});
        expo  <= ExpW'(FracW - 1) - ExpW'(lead);
        bZero <= (bMag == '0);
      end
      if (strobe.seed) begin
        x <= satWide(widen(SeedA) - widen(mulRound(widen(SeedB), widen(dn))));
      end
      if (strobe.mulA) begin
        t <= mulRound(widen(dn), widen(x));
      end
      if (strobe.mulB) begin
        x <= mulRound(widen(x), widen(WordTwo - t));
      end
      if (strobe.denorm) begin
        recip <= bZero ? WordMax : scalePow2(x, expo);
      end
      if (strobe.finish) begin
        quotient <= negRes ? -qMag : qMag;
      end
    end
  end

  // R5: the output never takes the asymmetric minimum code
  p_no_min_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    quotient != WordMin);

  // R6: a nonzero result carries the XOR of the captured operand signs
  p_sign_rule_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && quotient != '0) |-> (quotient[WordW-1] == negRes));

  // R7: zero divisor with a dividend of at least one drives full scale
  p_zero_divisor_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && bZero && aMag >= (WordW'(1) << FracW)) |->
      (quotient == (negRes ? -WordMax : WordMax)));

  // R4: the reciprocal handed to the last multiply is strictly positive
  p_recip_positive_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |-> (recip > 0));

endmodule

// File: rtl/recip_divider.sv
module recip_divider
  import recip_div_pkg::*;
#(
  parameter int ITERS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic signed [WordW-1:0] dividend,
  input  logic signed [WordW-1:0] divisor,
  output logic signed [WordW-1:0] quotient,
  output logic                    done
);

  localparam int Latency = 2 * ITERS + 5;
  localparam int LatW    = $clog2(Latency + 2);

  strobe_t strobe;

  recip_div_ctrl #(.ITERS(ITERS)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe)
  );

  recip_div_path uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dividend (dividend),
    .divisor  (divisor),
    .quotient (quotient),
    .done     (done)
  );

  // Cycle counter since the last accepted start, for the latency check
  logic [LatW-1:0] sinceLoad;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceLoad <= '0;
    end else if (strobe.load) begin
      sinceLoad <= LatW'(1);
    end else if (sinceLoad != '1) begin
      sinceLoad <= sinceLoad + 1'b1;
    end
  end

  // R2: done arrives a fixed number of cycles after the accepted start
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sinceLoad == LatW'(Latency)));

  // R2: done lasts a single cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: tb/recip_divider_test.sv
`timescale 1ns/1ps
module recip_divider_test;

  localparam int     Iters   = 4;
  localparam int     Lat     = 2 * Iters + 5;
  localparam real    Scale   = 8388608.0;
  localparam longint MaxCode = 134217727;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signed [27:0] dividend = '0;
  logic signed [27:0] divisor = '0;
  logic signed [27:0] quotient;
  logic done;

  int checks = 0;
  int fails = 0;

  recip_divider #(.ITERS(Iters)) uut (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend),
    .divisor(divisor), .quotient(quotient), .done(done)
  );

  always #5 clk = ~clk;

  function automatic longint toCode(input real r);
    return (r >= 0.0) ? longint'($rtoi(r * Scale + 0.5)) : longint'($rtoi(r * Scale - 0.5));
  endfunction

  // Ideal model: reciprocal and product each clamped at full scale
  function automatic longint model(input longint a, input longint b);
    real maxR, am, bm, rec, q;
    longint c;
    maxR = real'(MaxCode) / Scale;
    am = real'(a < 0 ? -a : a) / Scale;
    bm = real'(b < 0 ? -b : b) / Scale;
    if (bm == 0.0) rec = maxR;
    else begin
      rec = 1.0 / bm;
      if (rec > maxR) rec = maxR;
    end
    q = am * rec;
    if (q > maxR) q = maxR;
    c = longint'($rtoi(q * Scale + 0.5));
    if (c > MaxCode) c = MaxCode;
    return ((a < 0) != (b < 0)) ? -c : c;
  endfunction

  task automatic checkEq(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic checkNear(input string tag, input longint got, input longint exp);
    longint diff, tol;
    checks++;
    diff = got - exp;
    if (diff < 0) diff = -diff;
    tol = 8 + (exp < 0 ? -exp : exp) / 200000;
    if (diff > tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, got, exp, tol);
    end
  endtask

  task automatic runOp(input longint a, input longint b, output longint q, output int lat);
    @(negedge clk);
    dividend = 28'(a);
    divisor  = 28'(b);
    start    = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    q = longint'(quotient);
  endtask

  task automatic divCheck(input string tag, input real a, input real b);
    longint q, ca, cb;
    int lat;
    ca = toCode(a);
    cb = toCode(b);
    runOp(ca, cb, q, lat);
    checkNear(tag, q, model(ca, cb));
  endtask

  task automatic testReset();
    checkEq("R1 done after reset", longint'(done), 0);
    checkEq("R1 quotient after reset", longint'(quotient), 0);
  endtask

  task automatic testLatency();
    longint q;
    int lat;
    runOp(toCode(2.0), toCode(0.5), q, lat);
    checkEq("R2 latency", longint'(lat), longint'(Lat));
    checkNear("R2 value 2/0.5", q, toCode(4.0));
    @(posedge clk);
    @(negedge clk);
    checkEq("R2 done one cycle", longint'(done), 0);
  endtask

  task automatic testInRange();
    divCheck("R3 1/0.7", 1.0, 0.7);
    divCheck("R3 1/0.07", 1.0, 0.07);
    divCheck("R3 0.5/2", 0.5, 2.0);
    divCheck("R3 3.3/7.9", 3.3, 7.9);
    divCheck("R3 0.001/0.2", 0.001, 0.2);
  endtask

  task automatic testClamp();
    longint q;
    int lat;
    runOp(toCode(0.1), toCode(0.01), q, lat);
    checkNear("R4 0.1/0.01", q, model(toCode(0.1), toCode(0.01)));
    checks++;
    if (q < toCode(1.59) || q > toCode(1.61)) begin
      fails++;
      $display("FAIL R4 0.1/0.01 near 1.6: actual %0d expected about %0d", q, toCode(1.6));
    end
    divCheck("R4 0.1/0.0625", 0.1, 0.0625);
    divCheck("R4 0.5/-0.03", 0.5, -0.03);
  endtask

  task automatic testSaturate();
    longint q;
    int lat;
    runOp(toCode(8.0), toCode(0.25), q, lat);
    checkEq("R5 +saturation", q, MaxCode);
    runOp(toCode(-8.0), toCode(0.25), q, lat);
    checkEq("R5 -saturation", q, -MaxCode);
  endtask

  task automatic testSign();
    longint q1, q2, q3, q4;
    int lat;
    runOp(toCode(7.25), toCode(3.1), q1, lat);
    runOp(toCode(-7.25), toCode(3.1), q2, lat);
    runOp(toCode(7.25), toCode(-3.1), q3, lat);
    runOp(toCode(-7.25), toCode(-3.1), q4, lat);
    checkNear("R6 ++", q1, model(toCode(7.25), toCode(3.1)));
    checkEq("R6 -+ mirrors", q2, -q1);
    checkEq("R6 +- mirrors", q3, -q1);
    checkEq("R6 -- equals", q4, q1);
  endtask

  task automatic testZeroDiv();
    longint q;
    int lat;
    runOp(toCode(-1.0), 0, q, lat);
    checkEq("R7 -1/0", q, -MaxCode);
    runOp(toCode(0.5), 0, q, lat);
    checkNear("R7 0.5/0", q, model(toCode(0.5), 0));
    runOp(0, 0, q, lat);
    checkEq("R7 0/0", q, 0);
  endtask

  task automatic testBusy();
    int pulses = 0;
    int firstAt = 0;
    longint firstQ = 0;
    @(negedge clk);
    dividend = 28'(toCode(1.0));
    divisor  = 28'(toCode(0.7));
    start    = 1'b1;
    for (int cyc = 1; cyc <= 40; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      start = (cyc == 3);
      if (cyc == 3) begin
        dividend = 28'(toCode(2.0));
        divisor  = 28'(toCode(0.5));
      end
      if (done) begin
        pulses++;
        if (pulses == 1) begin
          firstAt = cyc;
          firstQ  = longint'(quotient);
        end
      end
    end
    start = 1'b0;
    checkEq("R8 one done", longint'(pulses), 1);
    checkEq("R8 latency kept", longint'(firstAt), longint'(Lat));
    checkNear("R8 first operands", firstQ, model(toCode(1.0), toCode(0.7)));
  endtask

  task automatic testLatch();
    longint q;
    int lat = 1;
    @(negedge clk);
    dividend = 28'(toCode(3.0));
    divisor  = 28'(toCode(1.5));
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start    = 1'b0;
    dividend = 28'(toCode(-1.0));
    divisor  = 28'(toCode(0.25));
    while (!done && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    q = longint'(quotient);
    checkNear("R9 captured operands", q, toCode(2.0));
  endtask

  task automatic testMinDivisor();
    longint q;
    int lat;
    runOp(toCode(1.0), -134217728, q, lat);
    checkNear("R10 1/-16", q, -toCode(0.0625));
    divCheck("R10 3/15.99", 3.0, 15.99);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R2 watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testLatency();
    testInRange();
    testClamp();
    testSaturate();
    testSign();
    testZeroDiv();
    testBusy();
    testLatch();
    testMinDivisor();
    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule